// File: doc/BRIEF.md
# Packed Double-Precision Compare Unit

This block compares two 128-bit operands, each carrying two IEEE-754 binary64 values, and returns one 64-bit mask per lane. A lane's mask is all ones when the selected relation holds between its first-operand value and its second-operand value, and all zeros otherwise. The relation comes from the low three bits of an 8-bit immediate. The upper immediate bits are ignored.

Along with the mask, the unit returns two flags. One reports an invalid-operation condition and the other reports a subnormal operand. Each flag is the OR of the condition over both lanes of the current operation.

Each operation is accepted on a clock edge where the input strobe is high. Its mask and flags appear in registers one cycle later, together with a result-valid strobe. Greater-than relations are not decoded. A caller gets them by swapping the operands and using a less-than form.

Top module: `pdcmp_unit`

## Requirements
- R1: Immediate bits [2:0] choose the relation: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. Immediate bits [7:3] have no effect on the mask or the flags.
- R2: Lane 0 compares A[63:0] with B[63:0] and drives mask bits [63:0]. Lane 1 compares A[127:64] with B[127:64] and drives mask bits [127:64]. Each lane mask is all ones when its relation holds and all zeros otherwise, independent of the other lane.
- R3: A NaN is an operand with exponent all ones and a nonzero fraction. If either operand of a lane is a NaN, the relation is false for equal, less-than, less-or-equal and ordered, and true for not-equal, not-less-than and not-less-or-equal.
- R4: Unordered is true when at least one operand of the lane is a NaN. Ordered is true when neither operand is a NaN.
- R5: For non-NaN operands, +0 and -0 compare equal. Ordering follows real-number value, including subnormals and both infinities.
- R6: A quiet NaN has fraction bit 51 set. A quiet NaN in either operand of either lane sets the invalid flag only for less-than, less-or-equal, not-less-than and not-less-or-equal.
- R7: A signaling NaN has fraction bit 51 clear. A signaling NaN in any operand of either lane sets the invalid flag for every relation.
- R8: The denormal flag is set when any of the four operands has a zero exponent and a nonzero fraction. Zeros do not set it.
- R9: The result-valid output is high exactly one cycle after each accepted input. Mask and flags change only on that cycle and hold while no input is accepted.
- R10: While synchronous reset is high, and on the cycle after it, the result-valid output, the mask and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Accept operands and immediate on this edge |
| opnd_a | input | 128 | First operand, two binary64 lanes |
| opnd_b | input | 128 | Second operand, two binary64 lanes |
| imm | input | 8 | Relation select in bits [2:0], rest ignored |
| out_vld | output | 1 | Result registers hold a new result |
| res_mask | output | 128 | Per-lane all-ones / all-zeros masks |
| flag_invalid | output | 1 | Invalid-operation condition of the last result |
| flag_denorm | output | 1 | Subnormal operand seen in the last result |

## Verification
Every result is due exactly one clock after the edge that accepts it, because there is a single register stage between the operands and the mask and flags. The bench drives the operands on a falling edge, holds them across one rising edge, and drops the strobe on the next falling edge. It then reads out_vld, the mask and the flags at that falling edge, half a period after they were registered. The hold checks sample several idle falling edges in a row and expect the previous mask and flags unchanged with out_vld low.

// File: rtl/pdcmp_pkg.sv
package pdcmp_pkg;

  parameter int unsigned DEF_EXP_W  = 11;
  parameter int unsigned DEF_FRAC_W = 52;

  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic is_sub;
  } fp_class_t;

  // relations for which a quiet NaN is an invalid operation
  function automatic logic pred_traps_qnan(pred_e p);
    return (p == PRED_LT) || (p == PRED_LE) || (p == PRED_NLT) || (p == PRED_NLE);
  endfunction

endpackage

// File: rtl/pdcmp_classify.sv
module pdcmp_classify
  import pdcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] val,
  output fp_class_t         cls,
  output logic [WORD_W-2:0] mag
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_zero, frac_nz;

  always_comb begin
    exp_f    = val[WORD_W-2:FRAC_W];
    frac_f   = val[FRAC_W-1:0];
    exp_max  = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;

    cls.sign    = val[WORD_W-1];
    cls.is_nan  = exp_max & frac_nz;
    cls.is_snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
    cls.is_zero = exp_zero & ~frac_nz;
    cls.is_sub  = exp_zero & frac_nz;
    mag         = val[WORD_W-2:0];
  end

endmodule

// File: rtl/pdcmp_lane.sv
module pdcmp_lane
  import pdcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  fp_class_t         ca,
  input  fp_class_t         cb,
  input  logic [WORD_W-2:0] ma,
  input  logic [WORD_W-2:0] mb,
  input  pred_e             pred,
  output logic              hit,
  output logic              invalid,
  output logic              denorm
);

  logic any_nan, both_zero, mag_lt, mag_eq;
  logic rel_eq, rel_lt, rel_le;

  always_comb begin
    any_nan   = ca.is_nan | cb.is_nan;
    both_zero = ca.is_zero & cb.is_zero;
    mag_lt    = ma < mb;
    mag_eq    = ma == mb;

    rel_eq = ~any_nan & (both_zero | ((ca.sign == cb.sign) & mag_eq));

    if (any_nan || both_zero)      rel_lt = 1'b0;
    else if (ca.sign != cb.sign)   rel_lt = ca.sign;
    else if (ca.sign)              rel_lt = ~mag_lt & ~mag_eq;
    else                           rel_lt = mag_lt;

    rel_le = rel_lt | rel_eq;

    unique case (pred)
      PRED_EQ:    hit = rel_eq;
      PRED_LT:    hit = rel_lt;
      PRED_LE:    hit = rel_le;
      PRED_UNORD: hit = any_nan;
      PRED_NEQ:   hit = ~rel_eq;
      PRED_NLT:   hit = ~rel_lt;
      PRED_NLE:   hit = ~rel_le;
      PRED_ORD:   hit = ~any_nan;
      default:    hit = 1'b0;
    endcase

    invalid = ca.is_snan | cb.is_snan | (any_nan & pred_traps_qnan(pred));
    denorm  = ca.is_sub | cb.is_sub;
  end

endmodule

// File: rtl/pdcmp_unit.sv
module pdcmp_unit
  import pdcmp_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned BUS_W  = LANES * WORD_W,
  localparam int unsigned PRED_W = $bits(pred_e)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [BUS_W-1:0] opnd_a,
  input  logic [BUS_W-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm,
  output logic             out_vld,
  output logic [BUS_W-1:0] res_mask,
  output logic             flag_invalid,
  output logic             flag_denorm
);

  pred_e pred;
  logic  unused_rsvd;

  assign pred        = pred_e'(imm[PRED_W-1:0]);
  assign unused_rsvd = ^imm[IMM_W-1:PRED_W];

  fp_class_t         cls_a [LANES];
  fp_class_t         cls_b [LANES];
  logic [WORD_W-2:0] mag_a [LANES];
  logic [WORD_W-2:0] mag_b [LANES];
  logic [LANES-1:0]  hit_w, inv_w, den_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pdcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_a_i (
      .val (opnd_a[g*WORD_W +: WORD_W]),
      .cls (cls_a[g]),
      .mag (mag_a[g])
    );
    pdcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_b_i (
      .val (opnd_b[g*WORD_W +: WORD_W]),
      .cls (cls_b[g]),
      .mag (mag_b[g])
    );
    pdcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) lane_i (
      .ca      (cls_a[g]),
      .cb      (cls_b[g]),
      .ma      (mag_a[g]),
      .mb      (mag_b[g]),
      .pred    (pred),
      .hit     (hit_w[g]),
      .invalid (inv_w[g]),
      .denorm  (den_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld      <= 1'b0;
      res_mask     <= '0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        for (int l = 0; l < LANES; l++) begin
          res_mask[l*WORD_W +: WORD_W] <= {WORD_W{hit_w[l]}};
        end
        flag_invalid <= |inv_w;
        flag_denorm  <= |den_w;
      end
    end
  end

  // result timing
  assert_vld_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(res_mask) && $stable(flag_invalid) && $stable(flag_denorm)));

  // NaN in lane 0 makes EQ false there
  assert_nan_eq_false_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pred == PRED_EQ && (cls_a[0].is_nan || cls_b[0].is_nan))
      |=> (res_mask[WORD_W-1:0] == '0));

  // NaN in lane 0 makes UNORD true there
  assert_unord_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pred == PRED_UNORD && (cls_a[0].is_nan || cls_b[0].is_nan))
      |=> (res_mask[WORD_W-1:0] == '1));

  // any signaling NaN raises invalid
  assert_snan_invalid_R7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (cls_a[0].is_snan || cls_b[0].is_snan)) |=> flag_invalid);

  // no subnormal anywhere means no denormal flag
  assert_no_sub_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && den_w == '0) |=> !flag_denorm);

  // reset clears the result registers
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_vld && res_mask == '0 && !flag_invalid && !flag_denorm));

endmodule

// File: tb/pdcmp_unit_tb_top.sv
`timescale 1ns/1ps
module pdcmp_unit_tb_top;

  localparam int W = 64;

  localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] P_TWO  = 64'h4000000000000000;
  localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] N_TWO  = 64'hC000000000000000;
  localparam logic [63:0] P_ZERO = 64'h0000000000000000;
  localparam logic [63:0] N_ZERO = 64'h8000000000000000;
  localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN   = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN   = 64'h7FF0000000000001;
  localparam logic [63:0] P_SUB  = 64'h0000000000000001;
  localparam logic [63:0] N_SUB  = 64'h800FFFFFFFFFFFFF;
  localparam logic [63:0] P_MAX  = 64'h7FEFFFFFFFFFFFFF;

  logic clk = 1'b0;
  logic rst;
  logic in_vld;
  logic [127:0] opnd_a, opnd_b;
  logic [7:0] imm;
  logic out_vld;
  logic [127:0] res_mask;
  logic flag_invalid, flag_denorm;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pdcmp_unit dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .out_vld(out_vld), .res_mask(res_mask),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
  );

  // ---------------- reference model ----------------
  function automatic bit m_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic bit m_snan(logic [63:0] v);
    return m_nan(v) && !v[51];
  endfunction
  function automatic bit m_sub(logic [63:0] v);
    return (v[62:52] == 0) && (v[51:0] != 0);
  endfunction

  function automatic bit m_rel(logic [63:0] a, logic [63:0] b, logic [2:0] p);
    bit un;
    real ra, rb;
    un = m_nan(a) || m_nan(b);
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (p)
      3'd0: return !un && (ra == rb);
      3'd1: return !un && (ra <  rb);
      3'd2: return !un && (ra <= rb);
      3'd3: return un;
      3'd4: return un || (ra != rb);
      3'd5: return un || !(ra <  rb);
      3'd6: return un || !(ra <= rb);
      default: return !un;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one operation, check the result one cycle later
  task automatic do_op(input logic [127:0] a, input logic [127:0] b,
                       input logic [7:0] im, input string req);
    logic [127:0] e_mask;
    bit e_inv, e_den, anyq, anys;
    logic [2:0] p;
    p = im[2:0];
    anys = 0; anyq = 0; e_den = 0;
    for (int l = 0; l < 2; l++) begin
      e_mask[l*W +: W] = {W{m_rel(a[l*W +: W], b[l*W +: W], p)}};
      anys |= m_snan(a[l*W +: W]) || m_snan(b[l*W +: W]);
      anyq |= m_nan(a[l*W +: W]) || m_nan(b[l*W +: W]);
      e_den |= m_sub(a[l*W +: W]) || m_sub(b[l*W +: W]);
    end
    e_inv = anys || (anyq && (p == 3'd1 || p == 3'd2 || p == 3'd5 || p == 3'd6));
    @(negedge clk);
    opnd_a = a; opnd_b = b; imm = im; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk(out_vld === 1'b1, "R9", "out_vld", {127'd0, out_vld}, 128'd1);
    chk(res_mask === e_mask, req, "mask", res_mask, e_mask);
    chk({flag_invalid, flag_denorm} === {e_inv, e_den}, req, "flags",
        {126'd0, flag_invalid, flag_denorm}, {126'd0, e_inv, e_den});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1; in_vld = 1'b0; opnd_a = '0; opnd_b = '0; imm = '0;
    repeat (3) @(negedge clk);
    chk({out_vld, flag_invalid, flag_denorm} === 3'b000 && res_mask === '0, "R10",
        "reset state", res_mask, 128'd0);
    rst = 1'b0;
  endtask

  task automatic t_ordered();   // R1 R2 R5
    for (int p = 0; p < 8; p++) begin
      do_op({P_TWO, N_ONE}, {P_ONE, P_ONE}, 8'(p), "R1");
      do_op({P_ONE, N_TWO}, {P_ONE, N_ONE}, 8'(p), "R5");
      do_op({P_SUB, N_SUB}, {P_ZERO, P_SUB}, 8'(p), "R5");
    end
  endtask

  task automatic t_zeros_inf(); // R5
    for (int p = 0; p < 8; p++) begin
      do_op({N_ZERO, P_ZERO}, {P_ZERO, N_ZERO}, 8'(p), "R5");
      do_op({P_INF, N_INF}, {P_MAX, N_INF}, 8'(p), "R5");
    end
  endtask

  task automatic t_nan_lanes(); // R2 R3 R4 R6 R7
    for (int p = 0; p < 8; p++) begin
      do_op({P_ONE, QNAN}, {P_ONE, P_ONE}, 8'(p), "R3");
      do_op({P_ONE, P_TWO}, {QNAN, P_TWO}, 8'(p), "R6");
      do_op({SNAN, P_ONE}, {P_ONE, P_ONE}, 8'(p), "R7");
      do_op({P_ONE, P_ONE}, {P_ONE, SNAN}, 8'(p), "R4");
    end
  endtask

  task automatic t_denorm();    // R8
    do_op({P_ONE, P_ONE}, {N_SUB, P_ONE}, 8'd0, "R8");
    do_op({N_ZERO, P_ZERO}, {P_ZERO, N_ZERO}, 8'd2, "R8");
    do_op({P_SUB, QNAN}, {P_ONE, P_ONE}, 8'd1, "R8");
  endtask

  task automatic t_reserved();  // R1: upper immediate bits ignored
    do_op({P_ONE, N_ONE}, {P_TWO, N_ONE}, 8'hF9, "R1");
    do_op({QNAN, P_ONE}, {P_ONE, P_TWO}, 8'hA8, "R1");
    do_op({P_TWO, P_ONE}, {P_ONE, P_ONE}, 8'h5E, "R1");
  endtask

  task automatic t_hold();      // R9
    logic [127:0] m0;
    logic [1:0] f0;
    do_op({P_ONE, N_ONE}, {P_TWO, N_TWO}, 8'd1, "R9");
    m0 = res_mask; f0 = {flag_invalid, flag_denorm};
    opnd_a = {SNAN, P_SUB}; opnd_b = {QNAN, QNAN}; imm = 8'd3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!out_vld && res_mask === m0 && {flag_invalid, flag_denorm} === f0, "R9",
          "idle hold", res_mask, m0);
    end
  endtask

  task automatic t_mid_reset(); // R10
    do_op({SNAN, P_SUB}, {P_SUB, P_ONE}, 8'd3, "R10");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk({out_vld, flag_invalid, flag_denorm} === 3'b000 && res_mask === '0, "R10",
        "reset after op", res_mask, 128'd0);
  endtask

  initial begin
    t_reset();
    t_ordered();
    t_zeros_inf();
    t_nan_lanes();
    t_denorm();
    t_reserved();
    t_hold();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule